// File: doc/BRIEF.md
# Triple-Redundant Result Voter

Three redundant processing units compute the same operation and present their result words on three buses, each with its own valid strobe. This block compares the words and passes on the value that at least two units agree on. It also tracks each unit's fault history. The first time a unit disagrees, the block sends it a one-cycle restart request. If that unit disagrees a second time, the block removes it from voting for good. Voting then continues with the units that remain.

A compare takes place only in a cycle where every unit still in service asserts valid. If some of those units are valid but others are not, a timeout begins. When the timeout expires, each unit that failed to deliver is charged with a disagreement. With two units left, the block can only check that they match. A mismatch between them raises a no-majority pulse, and the last good word stays on the output. With one unit or none left, the block raises a fatal flag and stops voting. Two wrong units that agree with each other outvote the correct unit, which is then blamed. This is intended behaviour and the block makes no attempt to detect it.

Top module: `tmr_vote_guard`

## Requirements
- R1: A synchronous active-high reset returns every unit to the healthy state and clears `voteResult` to 0. It also drives `voteValid`, `noMajority`, `restartPulse`, `isolated` and `fatal` low.
- R2: When all three units are in service and all assert valid in the same cycle, and at least two of their words are equal, `voteResult` takes the agreed word and `voteValid` is high for exactly the next cycle.
- R3: A unit in the healthy state that is charged with a disagreement gets `restartPulse[i]` high for exactly one cycle, the cycle after the charge. It then counts as restarted. Bit i of every per-unit vector refers to unit i, and unit i's word is `unitResult[i]`.
- R4: A restarted unit that is charged again gets `isolated[i]` set from the next cycle, with no restart pulse. The flag stays set until reset, and that unit's valid and result are ignored from then on.
- R5: No compare takes place, and `voteValid` stays low, unless every unit not isolated asserts valid in the same cycle.
- R6: If at least one in-service unit is valid but not all of them are, for `timeoutLimit` consecutive cycles, each in-service unit not valid in that last cycle is charged with a disagreement. A limit of 0 acts as 1. The timeout produces no vote, and the count restarts whenever a cycle has no in-service unit valid.
- R7: With three units in service and three pairwise different words, `noMajority` pulses for one cycle, `voteResult` holds its value and no unit is charged.
- R8: With one unit isolated, the other two are compared. If they are equal they produce a vote. If they differ, `noMajority` pulses, `voteResult` holds and neither unit is charged.
- R9: With two or more units isolated, `fatal` is high and `voteValid` stays low.
- R10: If two units agree on a word that differs from the third unit's word, the two win the vote and the third unit is charged, whichever of them is actually right.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| unitValid | input | 3 | Per-unit result valid strobe |
| unitResult | input | 3*WIDTH | Result words; unit i in bits [i*WIDTH +: WIDTH] |
| timeoutLimit | input | TMO_W | Cycles of partial arrival before missing units are charged |
| voteResult | output | WIDTH | Last voted word |
| voteValid | output | 1 | One-cycle pulse when a new vote is loaded |
| noMajority | output | 1 | One-cycle pulse when the compared words have no majority |
| restartPulse | output | 3 | One-cycle restart request per unit |
| isolated | output | 3 | Unit removed from voting |
| fatal | output | 1 | Fewer than two units remain in service |

## Verification
The assertions assume that valid strobes and result words carry known values and stay steady around each rising edge. They also assume that `timeoutLimit` changes only while reset is held, because a limit that moves mid-count would shift the timeout cycle. The stimulus meets these assumptions: it changes inputs only on falling edges, loads each new limit during reset, and draws result words from a small set so that agreement, single dissent and three-way splits all happen often.

// File: rtl/tmr_vote_pkg.sv
package tmr_vote_pkg;
  localparam int NUM_UNITS = 3;

  typedef enum logic [1:0] {
    UNIT_OK      = 2'd0,
    UNIT_RETRIED = 2'd1,
    UNIT_OUT     = 2'd2
  } unitState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic [1:0] sel;
  } dpStrobe_t;
endpackage

// File: rtl/tmr_vote_datapath.sv
module tmr_vote_datapath
  import tmr_vote_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_UNITS-1:0][WIDTH-1:0]  unitResult,
  input  dpStrobe_t                        strobe,
  output logic [2:0]                       pairEq,
  output logic [WIDTH-1:0]                 voteResult
);
  // pairEq[0]: unit0 vs unit1, pairEq[1]: unit0 vs unit2, pairEq[2]: unit1 vs unit2
  localparam int PAIR_LO [3] = '{0, 0, 1};
  localparam int PAIR_HI [3] = '{1, 2, 2};

  for (genvar p = 0; p < 3; p++) begin : g_pair
    assign pairEq[p] = (unitResult[PAIR_LO[p]] == unitResult[PAIR_HI[p]]);
  end

  logic [WIDTH-1:0] pickWord;

  always_comb begin
    case (strobe.sel)
      2'd0:    pickWord = unitResult[0];
      2'd1:    pickWord = unitResult[1];
      default: pickWord = unitResult[2];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)              voteResult <= '0;
    else if (strobe.load) voteResult <= pickWord;
  end
endmodule

// File: rtl/tmr_vote_ctrl.sv
module tmr_vote_ctrl
  import tmr_vote_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_UNITS-1:0]  unitValid,
  input  logic [2:0]            pairEq,
  input  logic [TMO_W-1:0]      timeoutLimit,
  output dpStrobe_t             strobe,
  output logic                  voteValid,
  output logic                  noMajority,
  output logic [NUM_UNITS-1:0]  restartPulse,
  output logic [NUM_UNITS-1:0]  isolated,
  output logic                  fatal
);
  localparam int CNT_W = TMO_W + 1;

  unitState_e             unitState [NUM_UNITS];
  logic [NUM_UNITS-1:0]   active;
  logic [NUM_UNITS-1:0]   faultMask;
  logic [1:0]             activeCnt;
  logic                   compareNow, partialNow, timeoutHit, splitVote;
  logic [TMO_W-1:0]       waitCnt;
  logic [TMO_W-1:0]       effLimit;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_iso
    assign isolated[u] = (unitState[u] == UNIT_OUT);
  end

  assign active     = ~isolated;
  assign activeCnt  = 2'(active[0]) + 2'(active[1]) + 2'(active[2]);
  assign fatal      = (activeCnt < 2'd2);
  assign compareNow = !fatal && ((unitValid & active) == active);
  assign partialNow = !fatal && !compareNow && (|(unitValid & active));
  assign effLimit   = (timeoutLimit == '0) ? TMO_W'(1) : timeoutLimit;
  assign timeoutHit = partialNow &&
                      (({1'b0, waitCnt} + CNT_W'(1)) >= {1'b0, effLimit});

  always_comb begin
    strobe    = '0;
    faultMask = '0;
    splitVote = 1'b0;
    if (compareNow) begin
      if (activeCnt == 2'd3) begin
        if (pairEq[0] || pairEq[1]) begin
          strobe.load  = 1'b1;
          strobe.sel   = 2'd0;
          faultMask[1] = !pairEq[0];
          faultMask[2] = !pairEq[1];
        end else if (pairEq[2]) begin
          strobe.load  = 1'b1;
          strobe.sel   = 2'd1;
          faultMask[0] = 1'b1;
        end else begin
          splitVote = 1'b1;
        end
      end else begin
        // two survivors: only a match check is possible
        if (isolated[0]) begin
          strobe.sel  = 2'd1;
          strobe.load = pairEq[2];
        end else if (isolated[1]) begin
          strobe.sel  = 2'd0;
          strobe.load = pairEq[1];
        end else begin
          strobe.sel  = 2'd0;
          strobe.load = pairEq[0];
        end
        splitVote = !strobe.load;
      end
    end else if (timeoutHit) begin
      faultMask = active & ~unitValid;
    end
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    always_ff @(posedge clk) begin
      if (rst) begin
        unitState[u]    <= UNIT_OK;
        restartPulse[u] <= 1'b0;
      end else begin
        restartPulse[u] <= faultMask[u] && (unitState[u] == UNIT_OK);
        if (faultMask[u]) begin
          unitState[u] <= (unitState[u] == UNIT_OK) ? UNIT_RETRIED : UNIT_OUT;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      waitCnt    <= '0;
      voteValid  <= 1'b0;
      noMajority <= 1'b0;
    end else begin
      voteValid  <= strobe.load;
      noMajority <= splitVote;
      if (!partialNow || timeoutHit) waitCnt <= '0;
      else                           waitCnt <= waitCnt + TMO_W'(1);
    end
  end
endmodule

// File: rtl/tmr_vote_guard.sv
module tmr_vote_guard
  import tmr_vote_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int TMO_W = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_UNITS-1:0]            unitValid,
  input  logic [NUM_UNITS-1:0][WIDTH-1:0] unitResult,
  input  logic [TMO_W-1:0]                timeoutLimit,
  output logic [WIDTH-1:0]                voteResult,
  output logic                            voteValid,
  output logic                            noMajority,
  output logic [NUM_UNITS-1:0]            restartPulse,
  output logic [NUM_UNITS-1:0]            isolated,
  output logic                            fatal
);
  dpStrobe_t  strobe;
  logic [2:0] pairEq;

  tmr_vote_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .unitResult (unitResult),
    .strobe     (strobe),
    .pairEq     (pairEq),
    .voteResult (voteResult)
  );

  tmr_vote_ctrl #(.TMO_W(TMO_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .unitValid    (unitValid),
    .pairEq       (pairEq),
    .timeoutLimit (timeoutLimit),
    .strobe       (strobe),
    .voteValid    (voteValid),
    .noMajority   (noMajority),
    .restartPulse (restartPulse),
    .isolated     (isolated),
    .fatal        (fatal)
  );
endmodule

// File: rtl/tmr_vote_checker.sv
module tmr_vote_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       unitValid,
  input logic [WIDTH-1:0] voteResult,
  input logic             voteValid,
  input logic             noMajority,
  input logic [2:0]       restartPulse,
  input logic [2:0]       isolated,
  input logic             fatal
);
  // R3: a restart request never lasts two cycles on the same unit
  p_single_restart_r3: assert property (@(posedge clk) disable iff (rst)
    (restartPulse != 3'b0) |=> ((restartPulse & $past(restartPulse)) == 3'b0));

  // R4: a unit being restarted is not isolated
  p_no_pulse_isolated_r4: assert property (@(posedge clk) disable iff (rst)
    ((restartPulse & isolated) == 3'b0));

  // R4: isolation is permanent until reset
  p_isolation_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (isolated != 3'b0) |=> ((isolated & $past(isolated)) == $past(isolated)));

  // R5: a vote follows a cycle in which every in-service unit was valid
  p_vote_needs_all_r5: assert property (@(posedge clk) disable iff (rst)
    voteValid |-> $past((unitValid & ~isolated) == ~isolated));

  // R7: a split holds the output word
  p_hold_on_split_r7: assert property (@(posedge clk) disable iff (rst)
    noMajority |-> ($stable(voteResult) && !voteValid));

  // R8: a new vote changes nothing while no majority is flagged
  p_vote_or_split_r8: assert property (@(posedge clk) disable iff (rst)
    !(voteValid && noMajority));

  // R9: no vote once fewer than two units remain
  p_fatal_silent_r9: assert property (@(posedge clk) disable iff (rst)
    fatal |-> !voteValid);

  // R9: fatal agrees with the isolation count
  p_fatal_count_r9: assert property (@(posedge clk) disable iff (rst)
    fatal == ($countones(isolated) >= 2));
endmodule

bind tmr_vote_guard tmr_vote_checker #(.WIDTH(WIDTH)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .unitValid    (unitValid),
  .voteResult   (voteResult),
  .voteValid    (voteValid),
  .noMajority   (noMajority),
  .restartPulse (restartPulse),
  .isolated     (isolated),
  .fatal        (fatal)
);

// File: tb/test_tmr_vote_guard.sv
`timescale 1ns/1ps
module test_tmr_vote_guard;
  localparam int W = 32;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] vIn = '0;
  logic [W-1:0] rIn [3];
  logic [TW-1:0] limitIn = 8'd4;

  logic [W-1:0] voteResult;
  logic voteValid, noMajority, fatal;
  logic [2:0] restartPulse, isolated;

  int checks = 0, failures = 0, cycles = 0;
  bit started = 0, done = 0;

  // behavioural reference state
  int mState [3];          // 0 healthy, 1 restarted, 2 isolated
  logic [W-1:0] mRes;
  bit mVV, mNM;
  bit [2:0] mRst;
  int mWait;

  always #2 clk = ~clk;

  initial begin
    rIn[0] = '0; rIn[1] = '0; rIn[2] = '0;
  end

  tmr_vote_guard #(.WIDTH(W), .TMO_W(TW)) i_tmr_vote_guard (
    .clk(clk), .rst(rst), .unitValid(vIn),
    .unitResult({rIn[2], rIn[1], rIn[0]}),
    .timeoutLimit(limitIn),
    .voteResult(voteResult), .voteValid(voteValid), .noMajority(noMajority),
    .restartPulse(restartPulse), .isolated(isolated), .fatal(fatal)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model step
  always @(posedge clk) begin
    int nAct, win, agree, lim;
    bit allIn, anyIn;
    bit [2:0] fault;
    started = 1;
    if (rst) begin
      for (int u = 0; u < 3; u++) mState[u] = 0;
      mRes = '0; mVV = 0; mNM = 0; mRst = '0; mWait = 0;
    end else begin
      mVV = 0; mNM = 0; mRst = '0; fault = '0;
      nAct = 0;
      for (int u = 0; u < 3; u++) if (mState[u] != 2) nAct++;
      if (nAct >= 2) begin
        allIn = 1; anyIn = 0;
        for (int u = 0; u < 3; u++)
          if (mState[u] != 2) begin
            if (vIn[u]) anyIn = 1; else allIn = 0;
          end
        if (allIn) begin
          mWait = 0; win = -1;
          for (int u = 0; u < 3; u++)
            if (mState[u] != 2 && win < 0) begin
              agree = 0;
              for (int w = 0; w < 3; w++)
                if (mState[w] != 2 && rIn[w] == rIn[u]) agree++;
              if (agree >= 2) win = u;
            end
          if (win < 0) mNM = 1;
          else begin
            mVV = 1; mRes = rIn[win];
            for (int u = 0; u < 3; u++)
              if (mState[u] != 2 && rIn[u] != rIn[win]) fault[u] = 1;
          end
        end else if (anyIn) begin
          mWait++;
          lim = (limitIn == 0) ? 1 : int'(limitIn);
          if (mWait >= lim) begin
            for (int u = 0; u < 3; u++)
              if (mState[u] != 2 && !vIn[u]) fault[u] = 1;
            mWait = 0;
          end
        end else mWait = 0;
      end else mWait = 0;
      for (int u = 0; u < 3; u++)
        if (fault[u]) begin
          if (mState[u] == 0) begin mState[u] = 1; mRst[u] = 1; end
          else mState[u] = 2;
        end
    end
  end

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    bit [2:0] mIso;
    int nIso;
    if (started && !done) begin
      nIso = 0;
      for (int u = 0; u < 3; u++) begin
        mIso[u] = (mState[u] == 2);
        if (mState[u] == 2) nIso++;
      end
      chk(voteValid == mVV, rst ? "R1 voteValid" : "R2 voteValid", voteValid, mVV);
      chk(voteResult == mRes, rst ? "R1 voteResult" : "R2 voteResult", voteResult, mRes);
      chk(noMajority == mNM, rst ? "R1 noMajority" : "R7 noMajority", noMajority, mNM);
      chk(restartPulse == mRst, rst ? "R1 restartPulse" : "R3 restartPulse", restartPulse, mRst);
      chk(isolated == mIso, rst ? "R1 isolated" : "R4 isolated", isolated, mIso);
      chk(fatal == (nIso >= 2), rst ? "R1 fatal" : "R9 fatal", fatal, nIso >= 2);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(input logic [2:0] v, input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
    @(negedge clk);
    vIn = v; rIn[0] = a; rIn[1] = b; rIn[2] = c;
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  task automatic doReset(input logic [TW-1:0] lim);
    @(negedge clk);
    rst = 1; vIn = '0; limitIn = lim;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    doReset(8'd10);
    settle();
    chk(voteValid == 0 && isolated == 0 && fatal == 0 && restartPulse == 0, "R1 outputs after reset",
        {voteValid, isolated, fatal, restartPulse}, 0);
    chk(voteResult == 0, "R1 voteResult after reset", voteResult, 0);

    step(3'b111, 32'hA5A50001, 32'hA5A50001, 32'hA5A50001); settle();
    chk(voteValid && voteResult == 32'hA5A50001, "R2 unanimous vote", voteResult, 32'hA5A50001);

    step(3'b011, 32'h77, 32'h77, 32'h77); settle();
    chk(!voteValid, "R5 partial arrival gives no vote", voteValid, 0);
    step(3'b000, 0, 0, 0); settle();

    step(3'b111, 32'h100, 32'h100, 32'h200); settle();
    chk(restartPulse == 3'b100, "R3 restart on first dissent", restartPulse, 3'b100);
    chk(voteResult == 32'h100, "R2 majority word", voteResult, 32'h100);
    step(3'b000, 0, 0, 0); settle();
    chk(restartPulse == 3'b000, "R3 pulse lasts one cycle", restartPulse, 0);

    step(3'b111, 32'h300, 32'h300, 32'h301); settle();
    chk(isolated == 3'b100 && restartPulse == 0, "R4 isolate on second dissent", {isolated, restartPulse}, 6'b100000);

    step(3'b011, 32'h400, 32'h400, 32'hDEAD); settle();
    chk(voteValid && voteResult == 32'h400, "R8 two survivors agree", voteResult, 32'h400);
    step(3'b111, 32'h500, 32'h501, 32'h500); settle();
    chk(noMajority && !voteValid && voteResult == 32'h400, "R8 survivors split, output held", voteResult, 32'h400);
    chk(isolated == 3'b100 && restartPulse == 0, "R4 isolated unit ignored, no blame on split", {isolated, restartPulse}, 6'b100000);

    doReset(8'd10);
    step(3'b111, 32'h1, 32'h2, 32'h3); settle();
    chk(noMajority && voteResult == 0 && restartPulse == 0, "R7 three-way split", {noMajority, restartPulse}, 4'b1000);
    step(3'b111, 32'hBAD, 32'hBAD, 32'h600D); settle();
    chk(voteResult == 32'hBAD && restartPulse == 3'b100, "R10 wrong pair outvotes correct unit", restartPulse, 3'b100);

    doReset(8'd3);
    step(3'b011, 1, 1, 1); step(3'b011, 1, 1, 1); step(3'b000, 0, 0, 0); settle();
    chk(restartPulse == 0, "R6 idle cycle clears timeout count", restartPulse, 0);
    step(3'b011, 1, 1, 1); step(3'b011, 1, 1, 1); step(3'b011, 1, 1, 1); settle();
    chk(restartPulse == 3'b100 && !voteValid, "R6 timeout charges missing unit", restartPulse, 3'b100);

    doReset(8'd0);
    step(3'b011, 1, 1, 1); settle();
    chk(restartPulse == 3'b100, "R6 zero limit acts as one", restartPulse, 3'b100);

    doReset(8'd1);
    step(3'b001, 5, 5, 5); settle();
    chk(restartPulse == 3'b110, "R6 two missing units charged", restartPulse, 3'b110);
    step(3'b001, 5, 5, 5); settle();
    chk(fatal && isolated == 3'b110, "R9 two isolated is fatal", {fatal, isolated}, 4'b1110);
    step(3'b111, 9, 9, 9); settle();
    chk(!voteValid && fatal, "R9 no vote when fatal", voteValid, 0);

    // mixed traffic against the reference model
    for (int k = 0; k < 3000; k++) begin
      if (k % 60 == 0) doReset(TW'($urandom_range(0, 4)));
      step(($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b111,
           32'($urandom_range(1, 3)) * 32'h11,
           32'($urandom_range(1, 3)) * 32'h11,
           32'($urandom_range(1, 3)) * 32'h11);
    end
    step(3'b000, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule